// File: doc/BRIEF.md
# Loadable Status Flag Register

This block holds the condition flags of a small 8-bit datapath. It keeps three live flags: zero, carry and negative. A fourth flag position is reserved. The flags can be loaded from two places. One is the result of the arithmetic unit, from which the flags are derived on the fly. The other is the low nibble of the data bus, so that software can save the flags and put them back, for example around an interrupt. A source select input picks between the two. A latch enable lets the chosen value in on the rising clock edge.

When the register is read, it presents a full byte to the bus. The low nibble is the stored flags. The high nibble is a live copy of four external status lines, such as a "receive character waiting" indication from a serial port. The bus drive is modelled as a data word plus an output-enable, so a tri-state buffer or a bus mux can be placed outside the block. Branch decisions are made elsewhere.

Top module: `status_flag_reg`

## Requirements
- R1: An active-low reset clears all four stored flag bits, so bus_out[3:0] reads 0x0 after reset.
- R2: With latch_en=1 and load_sel=0, on the clock edge the zero flag (bit 0) becomes 1 if alu_result is 0x00, and 0 otherwise.
- R3: With latch_en=1 and load_sel=0, on the clock edge the negative flag (bit 2) takes alu_result[7].
- R4: With latch_en=1 and load_sel=0, on the clock edge the carry flag (bit 1) takes alu_carry_n unchanged. The carry input is active-low, so a stored 1 means no carry.
- R5: With latch_en=1 and load_sel=1, on the clock edge bits 2..0 take bus_in[2:0]. bus_in[7:3] has no effect.
- R6: With latch_en=0, the stored flags keep their value whatever the ALU, bus and select inputs do.
- R7: Bit 3 (the reserved flag) always reads 0, including after a bus load with bus_in[3]=1.
- R8: bus_out[7:4] follows ext_status in the same cycle, with no clock edge needed.
- R9: With out_en=0, bus_oe is 0 and bus_out is 0x00. With out_en=1, bus_oe is 1 and bus_out carries {ext_status, 0, N, C, Z}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; its release is expected to be synchronous |
| alu_result | input | 8 | Result byte from the arithmetic unit |
| alu_carry_n | input | 1 | Active-low carry out of the arithmetic unit |
| bus_in | input | 8 | Data bus value used to restore the flags |
| load_sel | input | 1 | Flag source: 0 = ALU-derived, 1 = data bus |
| latch_en | input | 1 | Load the selected flags on the next rising edge |
| out_en | input | 1 | Drive the register byte onto the bus |
| ext_status | input | 4 | Live external status shown in the upper nibble |
| bus_out | output | 8 | Register byte toward the bus (0 when not enabled) |
| bus_oe | output | 1 | Bus drive enable for the external buffer |

## Verification
A wrong stored flag shows on bus_out[3:0] whenever out_en is high. It appears one edge after the load that caused it, and it persists until the next latch. A wrong derivation or a wrong mux choice is therefore seen on the first read after a single load. Each vector loads and then reads back on the next cycle. A failure to hold shows only if the inputs change while latch_en is low, so the bench changes every input during that window before it reads. Faults in the upper nibble and in the enable are combinational, so they are visible at the ports with no clock edge.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int FLAG_W = 4;

  typedef struct packed {
    logic rsv;
    logic neg;
    logic cy;
    logic zero;
  } flags_t;
endpackage

// File: rtl/flag_derive.sv
module flag_derive
  import flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] result,
  input  logic              carry_n,
  output flags_t            derived
);
  always_comb begin
    derived.zero = (result == '0);
    derived.cy   = carry_n;
    derived.neg  = result[DATA_W-1];
    derived.rsv  = 1'b0;
  end
endmodule

// File: rtl/flag_src_mux.sv
module flag_src_mux
  import flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              sel_bus,
  input  flags_t            from_alu,
  input  logic [DATA_W-1:0] from_bus,
  output flags_t            chosen
);
  flags_t bus_flags;

  always_comb begin
    bus_flags      = flags_t'(from_bus[FLAG_W-1:0]);
    bus_flags.rsv  = 1'b0;
    chosen         = sel_bus ? bus_flags : from_alu;
  end
endmodule

// File: rtl/flag_store.sv
module flag_store
  import flag_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t d_in,
  output flags_t q_out
);
  flags_t q_r;
  flags_t q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load) q_nxt = d_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_out = q_r;
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry_n,
  input  logic [DATA_W-1:0] bus_in,
  input  logic              load_sel,
  input  logic              latch_en,
  input  logic              out_en,
  input  logic [DATA_W-FLAG_W-1:0] ext_status,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  localparam int STATUS_W = DATA_W - FLAG_W;

  flags_t alu_flags;
  flags_t sel_flags;
  flags_t flag_q;
  logic [DATA_W-1:0] read_word;

  flag_derive #(.DATA_W(DATA_W)) u_derive (
    .result  (alu_result),
    .carry_n (alu_carry_n),
    .derived (alu_flags)
  );

  flag_src_mux #(.DATA_W(DATA_W)) u_mux (
    .sel_bus  (load_sel),
    .from_alu (alu_flags),
    .from_bus (bus_in),
    .chosen   (sel_flags)
  );

  flag_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (latch_en),
    .d_in  (sel_flags),
    .q_out (flag_q)
  );

  always_comb begin
    read_word = {ext_status[STATUS_W-1:0], 1'b0, flag_q.neg, flag_q.cy, flag_q.zero};
    bus_out   = out_en ? read_word : '0;
    bus_oe    = out_en;
  end
endmodule

// File: rtl/status_flag_reg_chk.sv
module status_flag_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] alu_result,
  input logic       alu_carry_n,
  input logic [7:0] bus_in,
  input logic       load_sel,
  input logic       latch_en,
  input logic       out_en,
  input logic [3:0] ext_status,
  input logic [7:0] bus_out,
  input logic       bus_oe,
  input logic [3:0] flag_q
);
  AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> $stable(flag_q)); // R6
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && !load_sel) |=> (flag_q[0] == ($past(alu_result) == 8'h00))); // R2
  AST_CARRY_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && !load_sel) |=> (flag_q[1] == $past(alu_carry_n))); // R4
  AST_NEG_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && !load_sel) |=> (flag_q[2] == $past(alu_result[7]))); // R3
  AST_BUS_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && load_sel) |=> (flag_q[2:0] == $past(bus_in[2:0]))); // R5
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out[3] == 1'b0); // R7
  AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (bus_out[7:4] == ext_status)); // R8
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (bus_out == 8'h00 && !bus_oe)); // R9
endmodule

bind status_flag_reg status_flag_reg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alu_result  (alu_result),
  .alu_carry_n (alu_carry_n),
  .bus_in      (bus_in),
  .load_sel    (load_sel),
  .latch_en    (latch_en),
  .out_en      (out_en),
  .ext_status  (ext_status),
  .bus_out     (bus_out),
  .bus_oe      (bus_oe),
  .flag_q      (flag_q)
);

// File: tb/status_flag_reg_bench.sv
module status_flag_reg_bench;
  logic       clk;
  logic       rst_n;
  logic [7:0] alu_result;
  logic       alu_carry_n;
  logic [7:0] bus_in;
  logic       load_sel;
  logic       latch_en;
  logic       out_en;
  logic [3:0] ext_status;
  logic [7:0] bus_out;
  logic       bus_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  status_flag_reg u_status_flag_reg (
    .clk(clk), .rst_n(rst_n), .alu_result(alu_result), .alu_carry_n(alu_carry_n),
    .bus_in(bus_in), .load_sel(load_sel), .latch_en(latch_en), .out_en(out_en),
    .ext_status(ext_status), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // vector: {sel, alu[7:0], carry_n, bus[7:0], ext[3:0], expected[7:0]}
  localparam int NV = 8;
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b1, 8'h00, 4'h0, 8'h03},
    {1'b0, 8'h80, 1'b0, 8'hFF, 4'hA, 8'hA4},
    {1'b0, 8'h7F, 1'b1, 8'h00, 4'h5, 8'h52},
    {1'b0, 8'hFF, 1'b0, 8'h07, 4'hF, 8'hF4},
    {1'b1, 8'h00, 1'b1, 8'hFF, 4'h0, 8'h07},
    {1'b1, 8'h55, 1'b0, 8'h0A, 4'h3, 8'h32},
    {1'b1, 8'h00, 1'b1, 8'hF0, 4'hC, 8'hC0},
    {1'b0, 8'h01, 1'b0, 8'h00, 4'h1, 8'h10}
  };

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; alu_result = 8'h00; alu_carry_n = 1'b0; bus_in = 8'hFF;
    load_sel = 1'b0; latch_en = 1'b0; out_en = 1'b1; ext_status = 4'h0;
    repeat (3) @(negedge clk);
    check("R1 reset", {1'b0, bus_out}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {1'b0, bus_out}, 9'h000);

    // table: load on one edge, read back on the following negedge
    for (int i = 0; i < NV; i++) begin
      load_sel    = VEC[i][29];
      alu_result  = VEC[i][28:21];
      alu_carry_n = VEC[i][20];
      bus_in      = VEC[i][19:12];
      ext_status  = VEC[i][11:8];
      latch_en    = 1'b1;
      @(negedge clk);
      check($sformatf("R2 R3 R4 R5 R7 R8 vec%0d", i), {1'b0, bus_out}, {1'b0, VEC[i][7:0]});
    end

    // R6: hold while inputs change; current flags are 0x0 (last vector)
    latch_en = 1'b0; load_sel = 1'b0; alu_result = 8'h00; alu_carry_n = 1'b1;
    @(negedge clk);
    load_sel = 1'b1; bus_in = 8'h07; alu_result = 8'h80;
    @(negedge clk);
    check("R6 hold", {1'b0, bus_out}, 9'h010);

    // R8: upper nibble follows without an edge
    @(posedge clk); #1;
    ext_status = 4'h9; #0.5;
    check("R8 live status", {1'b0, bus_out}, 9'h090);

    // R9: output enable
    @(negedge clk);
    out_en = 1'b0; #0.5;
    check("R9 disabled", {bus_oe, bus_out}, 9'h000);
    out_en = 1'b1; #0.5;
    check("R9 enabled", {bus_oe, bus_out}, 9'h190);

    // R5 and R7: bus load with bit3 set; upper bus bits ignored
    latch_en = 1'b1; load_sel = 1'b1; bus_in = 8'hAD;
    @(negedge clk);
    check("R5 R7 restore 0xAD", {1'b0, bus_out}, 9'h095);

    // R1: reset mid-run clears the loaded flags
    latch_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", {1'b0, bus_out}, 9'h090);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule